// File: doc/BRIEF.md
# Playback Period Counter and Interrupt

This block follows the playback side of an audio codec's DMA byte stream. While playback is enabled and the selected sample format and rate are usable, it holds a DMA request. It counts the bytes the DMA engine delivers, and when a programmed period has been moved it flags a playback interrupt. The period is programmed in samples through a 16-bit base count. The block converts that count into a byte threshold using the active format and the channel count.

The register block around it supplies four things: the base count (high register byte in the upper half), the decoded 3-bit format code, the stereo flag and the interrupt-enable bit. It also forwards two acknowledge strobes. One comes from a write to the status register. The other comes from a write that clears the playback bit in the alternate status register. The block returns the pending bit for the status register (bit 0), the pending bit for the alternate status register (bit 4) and the interrupt line.

Top module: `pdc_top`

## Requirements
- R1: After reset, dma_req_o, status_int_o, pend_pi_o and irq_o are all 0.
- R2: The byte threshold is base_cnt_i shifted left. Formats U8 (code 0), mu-law (code 1) and A-law (code 3) shift by 1 when stereo and by 0 when mono. Formats 16-bit little-endian (code 2) and 16-bit big-endian (code 6) shift by 2 when stereo and by 1 when mono.
- R3: Bytes are counted only while irq_en_i is 1. While irq_en_i is 0 no interrupt is raised and the partial count is kept.
- R4: The byte that brings the count to the threshold sets status_int_o, pend_pi_o and irq_o one cycle later. The count then restarts from zero for the next period.
- R5: When playback starts (play_en_i goes high with a valid format and rate), dma_req_o rises one cycle later and the byte count is cleared.
- R6: When play_en_i goes low, dma_req_o drops one cycle later.
- R7: A format code of 4, 5 or 7, or rate_bad_i at 1, drops dma_req_o one cycle later.
- R8: ack_status_i or ack_pi_i clears status_int_o, pend_pi_o and irq_o one cycle later.
- R9: When a threshold hit and an acknowledge occur in the same cycle, the interrupt stays pending.
- R10: A threshold of zero with irq_en_i at 1 deasserts dma_req_o and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_en_i | input | 1 | Playback enable |
| rate_bad_i | input | 1 | Selected sample rate is unsupported |
| fmt_i | input | 3 | Decoded format code |
| stereo_i | input | 1 | Two channels |
| irq_en_i | input | 1 | Period interrupt enable |
| base_cnt_i | input | CNT_W | Period length in samples, {high, low} |
| byte_ack_i | input | 1 | One byte accepted from the DMA stream |
| ack_status_i | input | 1 | Status register write acknowledge |
| ack_pi_i | input | 1 | Playback pending bit cleared by software |
| dma_req_o | output | 1 | DMA request level |
| status_int_o | output | 1 | Status register interrupt bit |
| pend_pi_o | output | 1 | Alternate status playback pending bit |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the block with the default CNT_W of 16, so the counter is 18 bits wide. Short periods of one to three samples reach every branch of the shift selection within a few dozen bytes. A base count of 0x0101 drives a period of 257 bytes, which shows that the upper register byte takes part in the threshold. Partial periods interrupted by enable toggles, by invalid formats and by interrupt-enable gaps check that the count is cleared or kept as required.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [2:0] {
    FMT_U8    = 3'd0,
    FMT_ULAW  = 3'd1,
    FMT_S16LE = 3'd2,
    FMT_ALAW  = 3'd3,
    FMT_RSV4  = 3'd4,
    FMT_ADPCM = 3'd5,
    FMT_S16BE = 3'd6,
    FMT_RSV7  = 3'd7
  } fmt_e;

  function automatic logic fmt_usable(input logic [2:0] f);
    return (f == FMT_U8) || (f == FMT_ULAW) || (f == FMT_ALAW) ||
           (f == FMT_S16LE) || (f == FMT_S16BE);
  endfunction

  function automatic logic fmt_wide(input logic [2:0] f);
    return (f == FMT_S16LE) || (f == FMT_S16BE);
  endfunction
endpackage

// File: rtl/pdc_thresh.sv
module pdc_thresh import pdc_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int XFER_W = CNT_W + 2
) (
  input  logic [2:0]        fmt_i,
  input  logic              stereo_i,
  input  logic [CNT_W-1:0]  base_i,
  output logic [XFER_W-1:0] thr_o,
  output logic              fmt_ok_o
);
  logic [1:0] sh;

  always_comb begin
    if (fmt_wide(fmt_i)) sh = stereo_i ? 2'd2 : 2'd1;
    else                 sh = {1'b0, stereo_i};
  end

  assign thr_o    = XFER_W'(base_i) << sh;
  assign fmt_ok_o = fmt_usable(fmt_i);
endmodule

// File: rtl/pdc_count.sv
module pdc_count #(
  parameter int XFER_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              count_en_i,
  input  logic [XFER_W-1:0] thr_i,
  output logic              hit_o
);
  logic [XFER_W-1:0] xfer_q;
  logic [XFER_W-1:0] xfer_nx;

  assign xfer_nx = xfer_q + 1'b1;
  // >= so a threshold lowered mid-period still terminates it
  assign hit_o   = count_en_i && (xfer_nx >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         xfer_q <= '0;
    else if (start_i)    xfer_q <= '0;
    else if (count_en_i) xfer_q <= hit_o ? '0 : xfer_nx;
  end

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !start_i) |=> (xfer_q == '0));
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (xfer_q == '0));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !start_i) |=> $stable(xfer_q));
endmodule

// File: rtl/pdc_irq.sv
module pdc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_status_i,
  input  logic ack_pi_i,
  output logic status_int_o,
  output logic pend_pi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_int_o <= 1'b0;
      pend_pi_o    <= 1'b0;
    end else if (hit_i) begin
      status_int_o <= 1'b1;
      pend_pi_o    <= 1'b1;
    end else if (ack_status_i || ack_pi_i) begin
      status_int_o <= 1'b0;
      pend_pi_o    <= 1'b0;
    end
  end

  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (status_int_o && pend_pi_o));
  a_r9_hit_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && (ack_status_i || ack_pi_i)) |=> status_int_o);
  a_r8_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && (ack_status_i || ack_pi_i)) |=> (!status_int_o && !pend_pi_o));
endmodule

// File: rtl/pdc_top.sv
module pdc_top import pdc_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             play_en_i,
  input  logic             rate_bad_i,
  input  logic [2:0]       fmt_i,
  input  logic             stereo_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] base_cnt_i,
  input  logic             byte_ack_i,
  input  logic             ack_status_i,
  input  logic             ack_pi_i,
  output logic             dma_req_o,
  output logic             status_int_o,
  output logic             pend_pi_o,
  output logic             irq_o
);
  localparam int XFER_W = CNT_W + 2;

  logic [XFER_W-1:0] thr;
  logic fmt_ok, run_d, run_q, start, count_en, hit;

  pdc_thresh #(.CNT_W(CNT_W), .XFER_W(XFER_W)) u_thresh (
    .fmt_i(fmt_i), .stereo_i(stereo_i), .base_i(base_cnt_i),
    .thr_o(thr), .fmt_ok_o(fmt_ok)
  );

  assign run_d = play_en_i && fmt_ok && !rate_bad_i;
  assign start = run_d && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  // zero period with interrupts on moves no data
  assign dma_req_o = run_q && !(irq_en_i && (thr == '0));
  assign count_en  = byte_ack_i && dma_req_o && irq_en_i;

  pdc_count #(.XFER_W(XFER_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .count_en_i(count_en), .thr_i(thr), .hit_o(hit)
  );

  pdc_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit),
    .ack_status_i(ack_status_i), .ack_pi_i(ack_pi_i),
    .status_int_o(status_int_o), .pend_pi_o(pend_pi_o)
  );

  assign irq_o = status_int_o;

  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_en_i |=> !dma_req_o);
  a_r7_bad_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_usable(fmt_i) || rate_bad_i) |=> !dma_req_o);
  a_r3_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !$rose(status_int_o));
  a_r10_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && base_cnt_i == '0) |=> !$rose(irq_o));
endmodule

// File: tb/pdc_top_tb.sv
module pdc_top_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic play_en = 0, rate_bad = 0, stereo = 0, irq_en = 0;
  logic [2:0] fmt = 3'd0;
  logic [CNT_W-1:0] base = '0;
  logic byte_ack = 0, ack_st = 0, ack_pi = 0;
  logic dma_req, st_int, pend_pi, irq;

  int n_chk = 0, n_bad = 0;
  bit exp_q[$];
  string tag_q[$];
  logic mon_due = 1'b0;

  // bench model
  bit m_run = 0, m_pend = 0;
  int m_xfer = 0, m_thr = 0;

  always #5 clk = ~clk;

  pdc_top #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .play_en_i(play_en), .rate_bad_i(rate_bad),
    .fmt_i(fmt), .stereo_i(stereo), .irq_en_i(irq_en), .base_cnt_i(base),
    .byte_ack_i(byte_ack), .ack_status_i(ack_st), .ack_pi_i(ack_pi),
    .dma_req_o(dma_req), .status_int_o(st_int), .pend_pi_o(pend_pi), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int calc_thr(int f, bit st, int b);
    int s;
    if (f == 2 || f == 6) s = st ? 2 : 1;
    else                  s = st ? 1 : 0;
    return b << s;
  endfunction

  function automatic bit f_ok(int f);
    return f == 0 || f == 1 || f == 2 || f == 3 || f == 6;
  endfunction

  task automatic cfg(int f, bit st, int b, bit ien, bit pe, bit rb);
    bit nrun;
    @(negedge clk);
    fmt = 3'(f); stereo = st; base = CNT_W'(b); irq_en = ien;
    play_en = pe; rate_bad = rb;
    nrun = pe && f_ok(f) && !rb;
    if (nrun && !m_run) m_xfer = 0;
    m_run = nrun;
    m_thr = calc_thr(f, st, b);
    @(negedge clk);
  endtask

  function automatic bit m_req();
    return m_run && !(irq_en && m_thr == 0);
  endfunction

  task automatic send_byte(string tag, bit with_ack);
    if (m_req() && irq_en) begin
      m_xfer++;
      if (m_xfer >= m_thr) begin
        m_xfer = 0;
        m_pend = 1;
      end else if (with_ack) m_pend = 0;
    end else if (with_ack) m_pend = 0;
    exp_q.push_back(m_pend);
    tag_q.push_back(tag);
    byte_ack = 1; ack_st = with_ack;
    @(negedge clk);
    byte_ack = 0; ack_st = 0;
  endtask

  task automatic bytes(string tag, int n);
    for (int i = 0; i < n; i++) send_byte(tag, 0);
    @(negedge clk);
  endtask

  task automatic do_ack(bit pi);
    ack_st = !pi; ack_pi = pi;
    @(negedge clk);
    ack_st = 0; ack_pi = 0;
    m_pend = 0;
    #1;
  endtask

  always @(posedge clk) mon_due <= byte_ack;

  always @(negedge clk) begin
    #2;
    if (mon_due && exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " irq"}, irq, e);
      chk({t, " pend_pi"}, pend_pi, e);
      chk({t, " status"}, st_int, e);
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 dma_req", dma_req, 0);
    chk("R1 irq", irq, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 dma_req", dma_req, 0);
    chk("R1 status", st_int, 0);
    chk("R1 pend_pi", pend_pi, 0);

    // R5 start, R2/R4 U8 mono base 3
    cfg(0, 0, 3, 1, 1, 0); #1;
    chk("R5 dma_req rises", dma_req, 1);
    bytes("R4 u8 mono", 3);
    do_ack(0);
    chk("R8 status ack", irq, 0);
    bytes("R4 second period", 3);
    do_ack(1);
    chk("R8 pi ack", pend_pi, 0);

    // R2 shifts
    cfg(0, 1, 2, 1, 1, 0); bytes("R2 u8 stereo", 4); do_ack(0);
    cfg(2, 0, 2, 1, 1, 0); bytes("R2 s16le mono", 4); do_ack(0);
    cfg(6, 1, 2, 1, 1, 0); bytes("R2 s16be stereo", 8); do_ack(0);
    cfg(1, 1, 1, 1, 1, 0); bytes("R2 ulaw stereo", 2); do_ack(0);
    cfg(3, 0, 3, 1, 1, 0); bytes("R2 alaw mono", 3); do_ack(0);

    // R3 gating and hold: 1 of 3, 5 bytes without IEN, 2 more
    cfg(0, 0, 3, 1, 0, 0);
    cfg(0, 0, 3, 1, 1, 0);
    bytes("R3 partial", 1);
    cfg(0, 0, 3, 0, 1, 0);
    bytes("R3 no ien", 5);
    cfg(0, 0, 3, 1, 1, 0);
    bytes("R3 resume", 2);
    do_ack(0);

    // R6 release, R5 clear on restart
    bytes("R5 partial", 2);
    cfg(0, 0, 3, 1, 0, 0); #1;
    chk("R6 dma_req drop", dma_req, 0);
    bytes("R6 ignored bytes", 2);
    cfg(0, 0, 3, 1, 1, 0); #1;
    chk("R5 dma_req again", dma_req, 1);
    bytes("R5 fresh period", 3);
    do_ack(0);

    // R7 bad format / rate
    cfg(4, 0, 3, 1, 1, 0); #1; chk("R7 fmt4", dma_req, 0);
    cfg(5, 0, 3, 1, 1, 0); #1; chk("R7 fmt5", dma_req, 0);
    cfg(7, 0, 3, 1, 1, 0); #1; chk("R7 fmt7", dma_req, 0);
    bytes("R7 ignored", 3);
    cfg(0, 0, 3, 1, 1, 1); #1; chk("R7 rate", dma_req, 0);
    cfg(0, 0, 3, 1, 1, 0); #1; chk("R7 recovered", dma_req, 1);

    // R9 hit with ack in same cycle
    bytes("R9 lead", 2);
    send_byte("R9 hit+ack", 1);
    @(negedge clk);
    do_ack(0);

    // R10 zero threshold
    cfg(0, 0, 0, 1, 1, 0); #1;
    chk("R10 dma_req", dma_req, 0);
    bytes("R10 no irq", 3);

    // R2 high byte of base count
    cfg(0, 0, 'h0101, 1, 1, 0);
    bytes("R2 high byte early", 256);
    bytes("R2 high byte hit", 1);
    do_ack(0);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule